// File: doc/BRIEF.md
# Bit-Banged GPIO Port Controller

This block is a small memory-mapped GPIO controller with two ports, called A and D, and a few plain storage words. Each port has three registers: a data-out register, an output-enable register and a data-in view that can only be read. Software moves two attached devices by writing the data-out registers, one bit at a time.

Three bits of the port A data-out register drive the address-latch, command-latch and chip-enable strobes of an attached NAND flash. On port D, changing one bit produces a clock edge for a serial temperature sensor, and another bit carries the serial data sent to it. When a data-in register is read, the result is that port's data-out ANDed with its output-enable, with one external status pin ORed in. On port A this pin is the NAND ready line. On port D it is the sensor's serial output.

The bus side takes a word index, which is the byte address divided by four. A write is a single-cycle strobe. Reads are combinational.

Top module: `gpio_bitbang_ctrl`

## Requirements
- R1: After reset every storage word holds zero. The NAND strobes, the sensor clock level, the sensor data line and the sensor clock event are all low.
- R2: A write to any in-range index other than a data-in index takes effect at the clock edge where wr_en is high. A later read of that index returns the written word.
- R3: A read of index 1 (port A data-in) returns word 0 AND word 2, with nand_ready ORed into bit 7.
- R4: A read of index 17 (port D data-in) returns word 16 AND word 18, with sens_so ORed into bit 4.
- R5: nand_ale follows bit 6 of word 0, nand_cle follows bit 5 and nand_ce follows bit 4. After a write to index 0, all three change at the clock edge of that write.
- R6: A write to index 16 whose bit 1 differs from the stored bit 1 raises sens_evt for the one cycle after that edge. From the same edge, sens_sck equals the new bit 1 and sens_si equals the new bit 4.
- R7: A write to index 16 whose bit 1 equals the stored bit 1 raises no sens_evt. It still updates sens_si from bit 4.
- R8: Indices 23 to 31 lie outside the 0x5C-byte space. Writes there change nothing, and reads there return zero.
- R9: sens_evt is low in the cycle after any edge with no write to index 16.
- R10: A write to index 1 or index 17 never changes what that index reads. The read is always formed as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | 5 | Word index (byte address / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| nand_ready | input | 1 | NAND ready pin |
| nand_ale | output | 1 | NAND address latch enable |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ce | output | 1 | NAND chip enable |
| sens_so | input | 1 | Sensor serial output |
| sens_evt | output | 1 | One-cycle sensor clock-edge event |
| sens_sck | output | 1 | Sensor clock level |
| sens_si | output | 1 | Serial data to the sensor |

## Verification
The bench writes to index 16 twice in a row with the same bit 1, and also in a row with bit 1 toggled. A design that compared against the wrong stored value would pulse on every write or miss the toggles. It reads both data-in indices with masks that differ and with each status pin at each level. A design that forgot the AND with output-enable, or injected a pin at the wrong bit, would return the wrong word. It writes to the data-in indices and to indices 23 to 31. A design that let those writes reach the read path would show the written data, and a design that wrapped the out-of-range index would corrupt a real word.

// File: rtl/gpio_bitbang_ctrl.sv
module gpio_bitbang_ctrl #(
  parameter int DW = 32,
  parameter int IW = 5,
  parameter int SPAN_BYTES = 92
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          nand_ready,
  output logic          nand_ale,
  output logic          nand_cle,
  output logic          nand_ce,
  input  logic          sens_so,
  output logic          sens_evt,
  output logic          sens_sck,
  output logic          sens_si
);
  localparam int NWORDS = SPAN_BYTES / 4;
  localparam logic [IW-1:0] PA_OUT = IW'(0);
  localparam logic [IW-1:0] PA_IN  = IW'(1);
  localparam logic [IW-1:0] PA_OE  = IW'(2);
  localparam logic [IW-1:0] PD_OUT = IW'(16);
  localparam logic [IW-1:0] PD_IN  = IW'(17);
  localparam logic [IW-1:0] PD_OE  = IW'(18);
  localparam int RDY_BIT = 7;
  localparam int SO_BIT  = 4;
  localparam int ALE_BIT = 6;
  localparam int CLE_BIT = 5;
  localparam int CE_BIT  = 4;
  localparam int SCK_BIT = 1;
  localparam int SI_BIT  = 4;

  logic [DW-1:0] regs [NWORDS];
  logic in_range;
  logic sck_flip;

  assign in_range = (32'(addr) < NWORDS);
  assign sck_flip = wr_en && (addr == PD_OUT) && (wdata[SCK_BIT] != regs[PD_OUT][SCK_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= '0;
      sens_evt <= 1'b0;
    end else begin
      if (wr_en && in_range) regs[addr] <= wdata;
      sens_evt <= sck_flip;
    end
  end

  assign nand_ale = regs[PA_OUT][ALE_BIT];
  assign nand_cle = regs[PA_OUT][CLE_BIT];
  assign nand_ce  = regs[PA_OUT][CE_BIT];
  assign sens_sck = regs[PD_OUT][SCK_BIT];
  assign sens_si  = regs[PD_OUT][SI_BIT];

  always_comb begin
    rdata = '0;
    if (in_range) begin
      case (addr)
        PA_IN:   rdata = (regs[PA_OUT] & regs[PA_OE]) | (DW'(nand_ready) << RDY_BIT);
        PD_IN:   rdata = (regs[PD_OUT] & regs[PD_OE]) | (DW'(sens_so) << SO_BIT);
        default: rdata = regs[addr];
      endcase
    end
  end

  // R5: a port A write shows on the strobes after its edge
  p_strobes_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PA_OUT) |=>
      (nand_ale == $past(wdata[ALE_BIT]) && nand_cle == $past(wdata[CLE_BIT]) &&
       nand_ce == $past(wdata[CE_BIT])));

  p_evt_is_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sens_evt |-> (sens_sck != $past(sens_sck)));

  p_no_evt_same_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == PD_OUT && wdata[SCK_BIT] == sens_sck) |=> !sens_evt);

  p_no_evt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == PD_OUT) |=> (!sens_evt && $stable(sens_sck) && $stable(sens_si)));

  p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(addr) >= NWORDS) |-> (rdata == '0));
endmodule

// File: tb/gpio_bitbang_ctrl_bench.sv
module gpio_bitbang_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int NW = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic nand_ready = 1'b0, sens_so = 1'b0;
  logic nand_ale, nand_cle, nand_ce, sens_evt, sens_sck, sens_si;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] m [NW];

  always #(PERIOD/2) clk = ~clk;

  gpio_bitbang_ctrl u_gpio_bitbang_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .nand_ready(nand_ready), .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_ce(nand_ce),
    .sens_so(sens_so), .sens_evt(sens_evt), .sens_sck(sens_sck), .sens_si(sens_si));

  function automatic logic [31:0] exp_read(input int idx, input logic rdy, input logic so);
    if (idx >= NW) return 32'h0;
    if (idx == 1) return (m[0] & m[2]) | (32'(rdy) << 7);
    if (idx == 17) return (m[16] & m[18]) | (32'(so) << 4);
    return m[idx];
  endfunction

  function automatic string tag_of(input int idx);
    if (idx >= NW) return "R8";
    if (idx == 1) return "R3";
    if (idx == 17) return "R4";
    return "R2";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, input string req);
    @(negedge clk);
    wr_en = 1'b0; addr = 5'(idx);
    #1;
    chk(req, rdata, exp_read(idx, nand_ready, sens_so));
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    logic ev;
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(idx); wdata = d;
    ev = (idx == 16) && (d[1] != m[16][1]);
    if (idx < NW) m[idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx == 16) chk(ev ? "R6 evt" : "R7 evt", 32'(sens_evt), 32'(ev));
    else chk("R9 evt", 32'(sens_evt), 32'h0);
    chk("R5 strobes", {29'h0, nand_ale, nand_cle, nand_ce}, {29'h0, m[0][6], m[0][5], m[0][4]});
    chk("R6 sck/si", {30'h0, sens_sck, sens_si}, {30'h0, m[16][1], m[16][4]});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NW; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 outputs", {26'h0, nand_ale, nand_cle, nand_ce, sens_evt, sens_sck, sens_si}, 32'h0);
    for (int i = 0; i < 32; i++) rd(i, i < NW ? "R1 reset word" : "R8 reset");

    // directed: port A strobes and data-in
    wr(0, 32'h0000_0070); wr(2, 32'h0000_00FF);
    nand_ready = 1'b1; rd(1, "R3 rdy high");
    nand_ready = 1'b0; rd(1, "R3 rdy low");
    wr(0, 32'h0000_0020); rd(1, "R3 mask");
    // directed: sensor edges
    wr(18, 32'hFFFF_FFFF);
    wr(16, 32'h0000_0012);
    wr(16, 32'h0000_0002);
    wr(16, 32'h0000_0000);
    wr(16, 32'h0000_0002);
    sens_so = 1'b1; rd(17, "R4 so high");
    sens_so = 1'b0; rd(17, "R4 so low");
    // R10: writes to data-in indices do not change their reads
    wr(1, 32'hDEAD_BEEF); rd(1, "R10 pa din");
    wr(17, 32'hCAFE_F00D); rd(17, "R10 pd din");
    // R8: out-of-range writes change nothing
    wr(23, 32'h1234_5678); wr(31, 32'h8765_4321);
    for (int i = 0; i < 32; i++) rd(i, i < NW ? "R8 no alias" : "R8 oob");
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int idx;
      idx = ($urandom % 3 == 0) ? (($urandom % 2 == 0) ? 16 : int'($urandom % 3)) : int'($urandom % 32);
      nand_ready = 1'($urandom);
      sens_so = 1'($urandom);
      if ($urandom % 2 == 0) wr(idx, $urandom);
      else rd(idx, tag_of(idx));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule